// File: doc/BRIEF.md
# Sticky Masked Overflow Interrupt Register

This block gathers overflow events from a set of channels (four by default) into a status register. Each status bit is active low and sticky. A mask register sits beside the status register and decides which channels can pull a single active-low interrupt line. The interrupt line feeds the enable of an open-drain pad; here it is modelled as a plain active-low output.

Software, through a control bus that lies outside this block, sees two registers:
- the status register at address 0, which is read-only and clears on read;
- the mask register at address 1, which can be read and written.

A read is a one-cycle strobe. It returns the register value on `rdata` after the clock edge. For the status register, the same edge resets the recorded bits, and any overflow arriving in that cycle is still kept. A channel whose mask bit is low goes on recording overflows but cannot raise the interrupt.

Top module: `ovf_irq_reg`

## Requirements
- R1: After reset the status register reads 0xFF, the mask register reads 0xFF and `irq_n` is high.
- R2: `ovf_evt[i]` high at a clock edge drives status bit i low after that edge. The bit stays low, whatever further events or mask writes occur, until the status register is read.
- R3: A read of address 0 (`rd_en` high) puts the status value from before the edge on `rdata` after that edge. The same edge returns every status bit to 1. Between reads, `rdata` holds its last value.
- R4: An overflow on channel i in the same cycle as a status read leaves status bit i low after the read.
- R5: `irq_n` is low exactly when some channel has its status bit low and its mask bit high.
- R6: A mask bit at 0 keeps its channel off `irq_n`, while the status bit still records that channel's overflows.
- R7: `wr_en` high with address 1 loads `wdata[3:0]` into the mask at the clock edge. A read of address 1 returns 0xF in bits 7:4 and the mask in bits 3:0.
- R8: Bits 7:4 of both registers are reserved. They always read as 1 and ignore written values.
- R9: A write to address 0 changes no status bit.
- R10: Reads of addresses 2 and 3 return 0xFF and leave the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovf_evt | input | 4 | Per-channel overflow strobe, one bit per channel |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 status, 1 mask |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, updated on the edge after a read strobe |
| irq_n | output | 1 | Active-low interrupt, drives the open-drain pad enable |

## Verification
The assertions take `rd_en` and `wr_en` as single-cycle strobes and the overflow inputs as synchronous to `clk`. They make no assumption about how reads, writes and events overlap. The stimulus drives every input half a cycle away from the active edge and holds each strobe for exactly one cycle. It deliberately overlaps an event with a status read and a write with an unmapped or read-only address, so that those orderings fall inside what the properties are written to cover.

// File: rtl/ovf_irq_pkg.sv
package ovf_irq_pkg;
   localparam int unsigned OVF_CH_DEF    = 4;
   localparam int unsigned OVF_REG_W_DEF = 8;
   localparam int unsigned OVF_ADDR_W    = 2;
   localparam logic [OVF_ADDR_W-1:0] OVF_ADDR_STAT = 2'd0;
   localparam logic [OVF_ADDR_W-1:0] OVF_ADDR_MASK = 2'd1;
endpackage

// File: rtl/ovf_stat_bank.sv
module ovf_stat_bank #(
   parameter int unsigned NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] evt,
   input  logic              clr,
   output logic [NUM_CH-1:0] stat_q
);
   // One sticky active-low cell per channel; an event wins over the clear.
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       stat_q[ch] <= 1'b1;
         else if (evt[ch]) stat_q[ch] <= 1'b0;
         else if (clr)     stat_q[ch] <= 1'b1;
      end
   end
endmodule

// File: rtl/ovf_mask_reg.sv
module ovf_mask_reg #(
   parameter int unsigned NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [NUM_CH-1:0] wbits,
   output logic [NUM_CH-1:0] mask_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mask_q <= '1;
      else if (we) mask_q <= wbits;
   end
endmodule

// File: rtl/ovf_rd_port.sv
module ovf_rd_port #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned REG_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_any,
   input  logic              sel_stat,
   input  logic              sel_mask,
   input  logic [NUM_CH-1:0] stat,
   input  logic [NUM_CH-1:0] mask,
   output logic [REG_W-1:0]  rdata
);
   logic [REG_W-1:0] stat_pad, mask_pad, rd_next;

   if (NUM_CH < REG_W) begin : g_pad
      assign stat_pad = {{(REG_W-NUM_CH){1'b1}}, stat};
      assign mask_pad = {{(REG_W-NUM_CH){1'b1}}, mask};
   end else begin : g_full
      assign stat_pad = stat;
      assign mask_pad = mask;
   end

   always_comb begin
      rd_next = '1;
      if (sel_stat)      rd_next = stat_pad;
      else if (sel_mask) rd_next = mask_pad;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata <= '1;
      else if (rd_any) rdata <= rd_next;
   end
endmodule

// File: rtl/ovf_irq_reg.sv
module ovf_irq_reg
   import ovf_irq_pkg::*;
#(
   parameter int unsigned NUM_CH    = OVF_CH_DEF,
   parameter int unsigned REG_W     = OVF_REG_W_DEF,
   parameter int unsigned ADDR_W    = OVF_ADDR_W,
   parameter logic [ADDR_W-1:0] STAT_ADDR = OVF_ADDR_STAT,
   parameter logic [ADDR_W-1:0] MASK_ADDR = OVF_ADDR_MASK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ovf_evt,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   output logic              irq_n
);
   if (NUM_CH == 0 || NUM_CH > REG_W) begin : g_bad_ch
      $error("ovf_irq_reg: NUM_CH must be 1..REG_W");
   end
   if (STAT_ADDR == MASK_ADDR) begin : g_bad_addr
      $error("ovf_irq_reg: status and mask addresses must differ");
   end

   logic              sel_stat, sel_mask, rd_stat, wr_mask;
   logic [NUM_CH-1:0] stat_q, mask_q;

   assign sel_stat = (addr == STAT_ADDR);
   assign sel_mask = (addr == MASK_ADDR);
   assign rd_stat  = rd_en & sel_stat;
   assign wr_mask  = wr_en & sel_mask;

   if (NUM_CH < REG_W) begin : g_rsv
      logic unused_rsv_bits;
      assign unused_rsv_bits = &{1'b0, wdata[REG_W-1:NUM_CH]};
   end

   ovf_stat_bank #(.NUM_CH(NUM_CH)) u_stat (
      .clk(clk), .rst_n(rst_n), .evt(ovf_evt), .clr(rd_stat), .stat_q(stat_q)
   );

   ovf_mask_reg #(.NUM_CH(NUM_CH)) u_mask (
      .clk(clk), .rst_n(rst_n), .we(wr_mask), .wbits(wdata[NUM_CH-1:0]),
      .mask_q(mask_q)
   );

   ovf_rd_port #(.NUM_CH(NUM_CH), .REG_W(REG_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_any(rd_en), .sel_stat(sel_stat),
      .sel_mask(sel_mask), .stat(stat_q), .mask(mask_q), .rdata(rdata)
   );

   assign irq_n = ~|(~stat_q & mask_q);
endmodule

// File: rtl/ovf_irq_chk.sv
module ovf_irq_chk #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned REG_W  = 8,
   parameter int unsigned ADDR_W = 2,
   parameter logic [ADDR_W-1:0] STAT_ADDR = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] ovf_evt,
   input logic              rd_en,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [NUM_CH-1:0] stat_q,
   input logic [NUM_CH-1:0] mask_q,
   input logic [REG_W-1:0]  rdata,
   input logic              irq_n
);
   logic rd_st, wr_st;
   assign rd_st = rd_en && (addr == STAT_ADDR);
   assign wr_st = wr_en && (addr == STAT_ADDR);

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      AST_EVT_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
         ovf_evt[ch] |=> !stat_q[ch]); // R2
      AST_STICKY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         (!stat_q[ch] && !rd_st) |=> !stat_q[ch]); // R2
      AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_st && !ovf_evt[ch]) |=> stat_q[ch]); // R3
      AST_EVT_SURVIVES_READ: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_st && ovf_evt[ch]) |=> !stat_q[ch]); // R4
      AST_UNMASKED_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
         (!stat_q[ch] && mask_q[ch]) |-> !irq_n); // R5
   end

   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> irq_n); // R6
   AST_PRECLEAR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rd_st |=> rdata[NUM_CH-1:0] == $past(stat_q)); // R3
   AST_RSV_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[REG_W-1:NUM_CH] == '1); // R8
   AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_st && !rd_en && ovf_evt == '0) |=> $stable(stat_q)); // R9
endmodule

bind ovf_irq_reg ovf_irq_chk #(
   .NUM_CH(NUM_CH), .REG_W(REG_W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)
) u_ovf_irq_chk (
   .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .rd_en(rd_en), .wr_en(wr_en),
   .addr(addr), .stat_q(stat_q), .mask_q(mask_q), .rdata(rdata), .irq_n(irq_n)
);

// File: tb/test_ovf_irq_reg.sv
module test_ovf_irq_reg;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ovf_evt = '0;
   logic       rd_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ovf_irq_reg i_ovf_irq_reg (
      .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .rd_en(rd_en),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
   );

   task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic chk1(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // Inputs change on the falling edge; outputs are sampled on the falling edge
   // that follows the rising edge which consumed them.
   task automatic reg_read(input logic [1:0] a, input logic [3:0] ev, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a; ovf_evt = ev;
      @(negedge clk);
      rd_en = 1'b0; ovf_evt = '0;
      d = rdata;
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [7:0] v);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input logic [3:0] ev);
      @(negedge clk);
      ovf_evt = ev;
      @(negedge clk);
      ovf_evt = '0;
   endtask

   task automatic t_reset;
      logic [7:0] d;
      chk1("R1 irq_n after reset", irq_n, 1'b1);
      chk8("R1 rdata after reset", rdata, 8'hFF);
      reg_read(2'd0, 4'h0, d); chk8("R1 status reset", d, 8'hFF);
      reg_read(2'd1, 4'h0, d); chk8("R1 mask reset", d, 8'hFF);
   endtask

   task automatic t_sticky;
      logic [7:0] d;
      pulse(4'b0010);
      chk1("R5 irq_n asserted", irq_n, 1'b0);
      repeat (5) @(negedge clk);
      chk1("R2 still pending", irq_n, 1'b0);
      chk8("R3 rdata held between reads", rdata, 8'hFF);
      reg_read(2'd0, 4'h0, d); chk8("R3 pre-clear status", d, 8'hFD);
      chk1("R3 irq cleared by read", irq_n, 1'b1);
      reg_read(2'd0, 4'h0, d); chk8("R3 status after clear", d, 8'hFF);
   endtask

   task automatic t_same_cycle;
      logic [7:0] d;
      pulse(4'b0001);
      reg_read(2'd0, 4'b0101, d); chk8("R4 read value", d, 8'hFE);
      chk1("R4 irq still asserted", irq_n, 1'b0);
      reg_read(2'd0, 4'h0, d); chk8("R4 event kept", d, 8'hFA);
      reg_read(2'd0, 4'h0, d); chk8("R4 cleared afterwards", d, 8'hFF);
   endtask

   task automatic t_mask;
      logic [7:0] d;
      reg_write(2'd1, 8'hFB);
      reg_read(2'd1, 4'h0, d); chk8("R7 mask readback", d, 8'hFB);
      pulse(4'b0100);
      chk1("R6 masked channel quiet", irq_n, 1'b1);
      reg_read(2'd0, 4'h0, d); chk8("R6 masked still recorded", d, 8'hFB);
      reg_write(2'd1, 8'h05);
      reg_read(2'd1, 4'h0, d); chk8("R8 reserved reads one", d, 8'hF5);
      pulse(4'b1000);
      chk1("R5 ch3 masked", irq_n, 1'b1);
      reg_write(2'd1, 8'h0D);
      chk1("R5 unmask pending ch3", irq_n, 1'b0);
      reg_read(2'd0, 4'h0, d); chk8("R8 status reserved ones", d, 8'hF7);
      reg_write(2'd1, 8'hFF);
   endtask

   task automatic t_stat_write;
      logic [7:0] d;
      pulse(4'b1000);
      reg_write(2'd0, 8'hFF);
      chk1("R9 irq unaffected", irq_n, 1'b0);
      reg_read(2'd0, 4'h0, d); chk8("R9 status write ignored", d, 8'hF7);
      reg_write(2'd0, 8'h00);
      reg_read(2'd0, 4'h0, d); chk8("R9 zero write ignored", d, 8'hFF);
   endtask

   task automatic t_unmapped;
      logic [7:0] d;
      pulse(4'b0001);
      reg_read(2'd2, 4'h0, d); chk8("R10 addr2 reads FF", d, 8'hFF);
      reg_read(2'd3, 4'h0, d); chk8("R10 addr3 reads FF", d, 8'hFF);
      chk1("R10 irq kept", irq_n, 1'b0);
      reg_read(2'd0, 4'h0, d); chk8("R10 status not cleared", d, 8'hFE);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sticky();
      t_same_cycle();
      t_mask();
      t_stat_write();
      t_unmapped();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule